// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block is the front end of a simple sequential 32-bit processor whose instructions range from one to six bytes. It keeps the program counter and presents it on an address port. A byte-addressed instruction memory returns the six bytes that start at that address. From those bytes the block takes apart the instruction: opcode, function code, two register specifiers and a 32-bit constant. It also works out the address of the next instruction in sequence.

On every clock edge the program counter moves to one of four places: the sequential address, the constant, a value returned by data memory, or a choice between the constant and the sequential address made by an external branch decision. Which one applies depends on the opcode. An undefined opcode flags the instruction as invalid and freezes the program counter. The register file, the ALU and the data memory sit outside this block. Their results come in as the `branchTaken` and `memReadValue` inputs.

Top module: `fetch_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to 0 at the next rising edge.
- R2: Instruction byte 0 (at `pc`) supplies `opcode` from bits 7:4 and `func` from bits 3:0.
- R3: Opcodes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB carry a register byte at `pc+1`. `regA` is its bits 7:4 and `regB` its bits 3:0. For every other opcode both outputs read 0xF.
- R4: The 32-bit constant is little-endian, with its lowest-addressed byte as the least significant byte. It starts at `pc+2` for opcodes 0x3, 0x4 and 0x5, and at `pc+1` for opcodes 0x7 and 0x8. For all other opcodes `constVal` is 0.
- R5: `fallThrough` is `pc` plus the instruction length:
  - 1 for opcodes 0x0 and 0x9;
  - 2 for opcodes 0x2, 0x6, 0xA and 0xB;
  - 5 for opcodes 0x7 and 0x8;
  - 6 for opcodes 0x3, 0x4 and 0x5.
- R6: For opcodes 0x0, 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB, the next `pc` is `fallThrough`.
- R7: For the jump opcode 0x7, the next `pc` is `constVal` when `branchTaken` is 1 and `fallThrough` when it is 0.
- R8: For the call opcode 0x8, the next `pc` is `constVal`.
- R9: For the return opcode 0x9, the next `pc` is `memReadValue`.
- R10: Opcodes 0x1 and 0xC to 0xF drive `instrValid` to 0 and leave `pc` unchanged across clock edges. Defined opcodes drive `instrValid` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchBytes | input | 48 | Instruction bytes at pc..pc+5; byte k is bits 8k+7:8k |
| branchTaken | input | 1 | Branch decision for the jump opcode |
| memReadValue | input | 32 | Return address read from data memory |
| pc | output | 32 | Current program counter (instruction fetch address) |
| opcode | output | 4 | Opcode field |
| func | output | 4 | Function code field |
| regA | output | 4 | First register specifier, 0xF if absent |
| regB | output | 4 | Second register specifier, 0xF if absent |
| constVal | output | 32 | Assembled constant, 0 if absent |
| fallThrough | output | 32 | Address of the next sequential instruction |
| instrValid | output | 1 | Opcode is defined |

## Verification
The case that is hardest to reach from the ports is a six-byte instruction at an odd, non-zero address, with its constant shifted one byte behind the register byte. The bench reaches it by running a short straight-line program: a one-byte and a two-byte instruction come first, so the six-byte forms are fetched at addresses 3 and 13. A byte image in the bench supplies the bytes at whatever address the design presents. The control transfers are also chained through that image: a not-taken jump, a taken jump, a call and a return. This places the invalid-opcode hold at an address that only a return could produce.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_MOVRR = 4'h2,
    OP_MOVIR = 4'h3,
    OP_STORE = 4'h4,
    OP_LOAD  = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opcode_e;

  typedef enum logic [1:0] {
    NEXT_FALL   = 2'd0,
    NEXT_CONST  = 2'd1,
    NEXT_MEM    = 2'd2,
    NEXT_BRANCH = 2'd3
  } next_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      valid;
    logic      hasRegByte;
    logic      hasConst;
    next_sel_e nextSel;
  } fetch_strobes_t;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic [3:0]     opcode,
  output fetch_strobes_t strobes
);

  always_comb begin
    strobes = '{valid: 1'b1, hasRegByte: 1'b0, hasConst: 1'b0, nextSel: NEXT_FALL};
    case (opcode)
      OP_NOP:   ;
      OP_MOVRR: strobes.hasRegByte = 1'b1;
      OP_ALU:   strobes.hasRegByte = 1'b1;
      OP_PUSH:  strobes.hasRegByte = 1'b1;
      OP_POP:   strobes.hasRegByte = 1'b1;
      OP_MOVIR, OP_STORE, OP_LOAD: begin
        strobes.hasRegByte = 1'b1;
        strobes.hasConst   = 1'b1;
      end
      OP_JUMP: begin
        strobes.hasConst = 1'b1;
        strobes.nextSel  = NEXT_BRANCH;
      end
      OP_CALL: begin
        strobes.hasConst = 1'b1;
        strobes.nextSel  = NEXT_CONST;
      end
      OP_RET:   strobes.nextSel = NEXT_MEM;
      default:  strobes.valid   = 1'b0;
    endcase
  end

endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_pkg::*;
#(
  parameter int CONST_BYTES = 4,
  parameter logic [3:0] NO_REG = 4'hF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [8*(CONST_BYTES+2)-1:0] fetchBytes,
  input  logic                       branchTaken,
  input  logic [8*CONST_BYTES-1:0]   memReadValue,
  input  fetch_strobes_t             strobes,
  output logic [8*CONST_BYTES-1:0]   pc,
  output logic [3:0]                 opcode,
  output logic [3:0]                 func,
  output logic [3:0]                 regA,
  output logic [3:0]                 regB,
  output logic [8*CONST_BYTES-1:0]   constVal,
  output logic [8*CONST_BYTES-1:0]   fallThrough
);

  localparam int ADDR_W      = 8 * CONST_BYTES;
  localparam int FETCH_BYTES = CONST_BYTES + 2;

  logic [7:0]        byteAt [FETCH_BYTES];
  logic [3:0]        instrLen;
  logic [ADDR_W-1:0] nextPc;

  for (genvar b = 0; b < FETCH_BYTES; b++) begin : g_split
    assign byteAt[b] = fetchBytes[8*b +: 8];
  end

  assign opcode = byteAt[0][7:4];
  assign func   = byteAt[0][3:0];
  assign regA   = strobes.hasRegByte ? byteAt[1][7:4] : NO_REG;
  assign regB   = strobes.hasRegByte ? byteAt[1][3:0] : NO_REG;

  // Constant: little-endian, shifted by one byte when a register byte precedes it
  for (genvar k = 0; k < CONST_BYTES; k++) begin : g_const
    assign constVal[8*k +: 8] = !strobes.hasConst ? 8'h00 :
                                (strobes.hasRegByte ? byteAt[k+2] : byteAt[k+1]);
  end

  always_comb begin
    instrLen = 4'd1 + {3'b000, strobes.hasRegByte}
             + (strobes.hasConst ? 4'(CONST_BYTES) : 4'd0);
  end

  assign fallThrough = pc + ADDR_W'(instrLen);

  always_comb begin
    nextPc = fallThrough;
    if (!strobes.valid) begin
      nextPc = pc;
    end else begin
      case (strobes.nextSel)
        NEXT_FALL:   nextPc = fallThrough;
        NEXT_CONST:  nextPc = constVal;
        NEXT_MEM:    nextPc = memReadValue;
        NEXT_BRANCH: nextPc = branchTaken ? constVal : fallThrough;
        default:     nextPc = fallThrough;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= nextPc;
  end

  // R5: two-byte ALU form advances by two
  a_r5_alu_len: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_ALU) |-> (fallThrough == pc + ADDR_W'(2)));

  // R6: ALU form proceeds sequentially
  a_r6_alu_seq: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_ALU) |=> (pc == $past(fallThrough)));

  a_r7_not_taken: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_JUMP && !branchTaken) |=> (pc == $past(fallThrough)));

  a_r7_taken: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_JUMP && branchTaken) |=> (pc == $past(constVal)));

  a_r8_call_target: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_CALL) |=> (pc == $past(constVal)));

  a_r9_ret_target: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_RET) |=> (pc == $past(memReadValue)));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.valid |=> $stable(pc));

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int CONST_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [8*(CONST_BYTES+2)-1:0]  fetchBytes,
  input  logic                          branchTaken,
  input  logic [8*CONST_BYTES-1:0]      memReadValue,
  output logic [8*CONST_BYTES-1:0]      pc,
  output logic [3:0]                    opcode,
  output logic [3:0]                    func,
  output logic [3:0]                    regA,
  output logic [3:0]                    regB,
  output logic [8*CONST_BYTES-1:0]      constVal,
  output logic [8*CONST_BYTES-1:0]      fallThrough,
  output logic                          instrValid
);

  fetch_strobes_t strobes;

  fetch_ctrl u_ctrl (
    .opcode (opcode),
    .strobes(strobes)
  );

  fetch_dp #(.CONST_BYTES(CONST_BYTES)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .fetchBytes  (fetchBytes),
    .branchTaken (branchTaken),
    .memReadValue(memReadValue),
    .strobes     (strobes),
    .pc          (pc),
    .opcode      (opcode),
    .func        (func),
    .regA        (regA),
    .regB        (regB),
    .constVal    (constVal),
    .fallThrough (fallThrough)
  );

  assign instrValid = strobes.valid;

endmodule

// File: tb/fetch_unit_bench.sv
`timescale 1ns/1ps
module fetch_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] fetchBytes;
  logic        branchTaken = 1'b0;
  logic [31:0] memReadValue = '0;
  logic [31:0] pc, constVal, fallThrough;
  logic [3:0]  opcode, func, regA, regB;
  logic        instrValid;

  logic [7:0] mem [256];
  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 6; i++) fetchBytes[8*i +: 8] = mem[pc[7:0] + 8'(i)];
  end

  fetch_unit u_fetch_unit (
    .clk(clk), .rst(rst), .fetchBytes(fetchBytes), .branchTaken(branchTaken),
    .memReadValue(memReadValue), .pc(pc), .opcode(opcode), .func(func),
    .regA(regA), .regB(regB), .constVal(constVal), .fallThrough(fallThrough),
    .instrValid(instrValid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic putBytes(input int addr, input logic [7:0] b [$]);
    foreach (b[i]) mem[8'(addr + i)] = b[i];
  endtask

  task automatic finishRun();
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check(pc === 32'h0, "R1 reset pc", pc, 32'h0);
  endtask

  task automatic testSequential();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    putBytes(0,  '{8'h00});
    putBytes(1,  '{8'h61, 8'h23});
    putBytes(3,  '{8'h30, 8'hF4, 8'h78, 8'h56, 8'h34, 8'h12});
    putBytes(9,  '{8'h20, 8'h45});
    putBytes(11, '{8'hA0, 8'h6F});
    putBytes(13, '{8'h50, 8'h12, 8'h10, 8'h00, 8'h00, 8'h00});
    doReset();
    check(fallThrough === 32'd1, "R5 nop length", fallThrough, 32'd1);
    check(regA === 4'hF, "R3 no reg byte", 32'(regA), 32'hF);
    check(constVal === 32'h0, "R4 no constant", constVal, 32'h0);
    step();
    check(pc === 32'd1, "R6 nop sequential", pc, 32'd1);
    check(opcode === 4'h6 && func === 4'h1, "R2 opcode/func split",
          {24'h0, opcode, func}, 32'h61);
    check(regA === 4'h2 && regB === 4'h3, "R3 register fields",
          {24'h0, regA, regB}, 32'h23);
    check(fallThrough === 32'd3, "R5 two-byte length", fallThrough, 32'd3);
    step();
    check(pc === 32'd3, "R6 alu sequential", pc, 32'd3);
    check(constVal === 32'h12345678, "R4 little-endian after reg byte", constVal, 32'h12345678);
    check(regB === 4'h4, "R3 regB with constant", 32'(regB), 32'h4);
    check(fallThrough === 32'd9, "R5 six-byte length", fallThrough, 32'd9);
    step();
    check(pc === 32'd9, "R6 imm move sequential", pc, 32'd9);
    step();
    check(pc === 32'd11, "R6 reg move sequential", pc, 32'd11);
    step();
    check(pc === 32'd13, "R6 push sequential", pc, 32'd13);
    check(constVal === 32'h10 && fallThrough === 32'd19, "R4 load constant", constVal, 32'h10);
    step();
    check(pc === 32'd19, "R6 load six bytes", pc, 32'd19);
  endtask

  task automatic testControl();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    putBytes(0,    '{8'h72, 8'h20, 8'h00, 8'h00, 8'h00});
    putBytes(5,    '{8'h70, 8'h40, 8'h00, 8'h00, 8'h00});
    putBytes(8'h40, '{8'h80, 8'h30, 8'h00, 8'h00, 8'h00});
    putBytes(8'h30, '{8'h90});
    putBytes(8'h11, '{8'hC5});
    putBytes(8'h60, '{8'h1F});
    doReset();
    branchTaken = 1'b0;
    check(constVal === 32'h20 && fallThrough === 32'd5, "R4 jump constant at pc+1", constVal, 32'h20);
    check(regA === 4'hF && regB === 4'hF, "R3 jump has no reg byte", {24'h0, regA, regB}, 32'hFF);
    step();
    check(pc === 32'd5, "R7 jump not taken", pc, 32'd5);
    branchTaken = 1'b1;
    step();
    check(pc === 32'h40, "R7 jump taken", pc, 32'h40);
    branchTaken = 1'b0;
    check(fallThrough === 32'h45, "R5 call length", fallThrough, 32'h45);
    step();
    check(pc === 32'h30, "R8 call target", pc, 32'h30);
    check(fallThrough === 32'h31, "R5 ret length", fallThrough, 32'h31);
    memReadValue = 32'h11;
    step();
    check(pc === 32'h11, "R9 return to memory value", pc, 32'h11);
    memReadValue = 32'h60;
    check(instrValid === 1'b0, "R10 opcode 0xC invalid", 32'(instrValid), 32'h0);
    step();
    step();
    check(pc === 32'h11, "R10 pc held", pc, 32'h11);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check(pc === 32'h0, "R1 reset mid-run", pc, 32'h0);
    check(instrValid === 1'b1, "R10 defined opcode valid", 32'(instrValid), 32'h1);
  endtask

  task automatic testOpcodeOne();
    // return lands on an opcode 0x1 byte at 0x60
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    putBytes(0, '{8'h90});
    putBytes(8'h60, '{8'h1F});
    memReadValue = 32'h60;
    doReset();
    step();
    check(pc === 32'h60, "R9 return target", pc, 32'h60);
    check(instrValid === 1'b0, "R10 opcode 0x1 invalid", 32'(instrValid), 32'h0);
    step();
    check(pc === 32'h60, "R10 pc held on 0x1", pc, 32'h60);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    testReset();
    testSequential();
    testControl();
    testOpcodeOne();
    finishRun();
  end

endmodule